// File: doc/BRIEF.md
# Width-Converting Dual-Clock Block RAM

This block is a 4,608-bit simple dual-port memory. It has one write port and one read port, and each port runs on its own clock. Each port has its own 3-bit shape code that picks one of six word shapes, from 4096 one-bit words up to 128 thirty-six-bit words. Data written in one shape can be read back in another shape, so the block also converts between bus widths. The storage is four banks of 128 nine-bit words. A 36-bit access uses all four banks in a single cycle. Narrower accesses pick one bank, or a pair of banks, and select the bit lanes they need inside that bank.

Read data leaves a register that is clocked by the read clock. A static pipeline input adds a second register stage. For depth stacking, each port has a 4-bit select that acts as upper address bits. The block responds only when that select equals its own 4-bit identity input, so up to 16 blocks can share one set of buses.

Top module: `mixed_width_ram`

## Requirements
- R1: Shape codes are 0=4096x1, 1=2048x2, 2=1024x4, 3=512x9, 4=256x18 and 5=128x36. The port uses address bits [11:0], [10:0], [9:0], [8:0], [7:0] and [6:0] respectively, and ignores the higher address bits.
- R2: Shape codes 6 and 7 are reserved. A write with a reserved code changes no stored bit. A read with a reserved code returns all zeros.
- R3: With pipeline off, the rclk_i edge that samples re_i high with a matching select loads the addressed word onto rdata_o. Writes take effect on wclk_i edges, independently of rclk_i.
- R4: With pipeline on, the new read data reaches rdata_o one rclk_i edge later than in R3. Until then, rdata_o keeps its previous value.
- R5: rdata_o holds its value while no read is accepted.
- R6: Shapes 0 to 2 share one layout. An element of width n at address a occupies bits (a*n mod 8) upward in the 9-bit word (a*n)/8. Bit 8 of each word is not reachable by these shapes, and a write changes only the element's own bits.
- R7: For shapes 3 to 5, a word of k nine-bit parts at address a is made of the 9-bit words a*k to a*k+k-1. The lowest of these words sits in rdata_o/wdata_i bits [8:0], the next in [17:9], and so on.
- R8: Data written with one shape reads back with any other shape according to the layouts of R6 and R7.
- R9: A write happens only when w_sel_i equals blk_id_i. A read is accepted only when r_sel_i equals blk_id_i. A read request with a non-matching select leaves rdata_o unchanged.
- R10: Reads narrower than 36 bits return data in the low bits of rdata_o, with the unused upper bits at zero.
- R11: A read and a write to different locations may proceed at the same time. Read data is undefined only when both ports address the same location at once.
- R12: After rst_ni is asserted, rdata_o is zero. Stored contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of the read registers |
| wclk_i | input | 1 | Write clock |
| we_i | input | 1 | Write request |
| w_width_i | input | 3 | Write shape code |
| w_sel_i | input | 4 | Write stack select (upper address) |
| waddr_i | input | 12 | Write address |
| wdata_i | input | 36 | Write data, low-aligned |
| rclk_i | input | 1 | Read clock |
| re_i | input | 1 | Read request |
| r_width_i | input | 3 | Read shape code |
| r_sel_i | input | 4 | Read stack select (upper address) |
| raddr_i | input | 12 | Read address |
| rdata_o | output | 36 | Read data, low-aligned |
| pipe_i | input | 1 | Static: adds a read output register stage |
| blk_id_i | input | 4 | Static identity of this block in a stack |

## Verification
The assertions assume that pipe_i and blk_id_i stay constant while reads are in flight. They also assume that the shape codes are steady around each accepted access, so that a read result can be matched to the shape that was sampled one edge earlier. The stimulus changes pipe_i only while the read port is idle. It ties blk_id_i to one value, and it drives every request input on the falling edge of its own clock. The phase that runs both ports concurrently keeps the writes in the upper half of the memory and the reads in the lower half, so it never creates the same-location collision whose read data is undefined.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int WORD_W = 9;
  localparam int N_BANK = 4;
  localparam int ROWS   = 128;
  localparam int ADDR_W = 12;
  localparam int DATA_W = WORD_W * N_BANK;
  localparam int SEL_W  = 4;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int BANK_W = $clog2(N_BANK);
  localparam int IDX_W  = ROW_W + BANK_W;

  typedef enum logic [2:0] {
    SH_X1  = 3'd0,
    SH_X2  = 3'd1,
    SH_X4  = 3'd2,
    SH_X9  = 3'd3,
    SH_X18 = 3'd4,
    SH_X36 = 3'd5
  } shape_e;

  // first 9-bit word touched by an access
  function automatic logic [IDX_W-1:0] word_idx(logic [2:0] sh, logic [ADDR_W-1:0] a);
    case (sh)
      SH_X1:   word_idx = a[11:3];
      SH_X2:   word_idx = a[10:2];
      SH_X4:   word_idx = a[9:1];
      SH_X9:   word_idx = a[8:0];
      SH_X18:  word_idx = {a[7:0], 1'b0};
      SH_X36:  word_idx = {a[6:0], 2'b00};
      default: word_idx = '0;
    endcase
  endfunction

  // bit offset inside the word for narrow shapes
  function automatic logic [2:0] bit_off(logic [2:0] sh, logic [ADDR_W-1:0] a);
    case (sh)
      SH_X1:   bit_off = a[2:0];
      SH_X2:   bit_off = {a[1:0], 1'b0};
      SH_X4:   bit_off = {a[0], 2'b00};
      default: bit_off = '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(logic [2:0] sh);
    case (sh)
      SH_X1:   lane_mask = 9'h001;
      SH_X2:   lane_mask = 9'h003;
      SH_X4:   lane_mask = 9'h00f;
      default: lane_mask = 9'h1ff;
    endcase
  endfunction
endpackage

// File: rtl/mwr_wr_map.sv
module mwr_wr_map
  import mwr_pkg::*;
(
  input  logic                               fire_i,
  input  logic [2:0]                         width_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  data_i,
  output logic [ROW_W-1:0]                   row_o,
  output logic [N_BANK-1:0]                  we_o,
  output logic [N_BANK-1:0][WORD_W-1:0]      mask_o,
  output logic [N_BANK-1:0][WORD_W-1:0]      data_o
);
  logic [IDX_W-1:0]  wi;
  logic [2:0]        off;
  logic [WORD_W-1:0] lm;

  always_comb begin
    wi     = word_idx(width_i, addr_i);
    off    = bit_off(width_i, addr_i);
    lm     = lane_mask(width_i);
    row_o  = wi[IDX_W-1:BANK_W];
    we_o   = '0;
    mask_o = '0;
    data_o = '0;
    for (int b = 0; b < N_BANK; b++) begin
      case (width_i)
        SH_X1, SH_X2, SH_X4: begin
          if (wi[BANK_W-1:0] == BANK_W'(b)) begin
            we_o[b]   = fire_i;
            mask_o[b] = lm << off;
            data_o[b] = (data_i[WORD_W-1:0] & lm) << off;
          end
        end
        SH_X9: begin
          if (wi[BANK_W-1:0] == BANK_W'(b)) begin
            we_o[b]   = fire_i;
            mask_o[b] = lm;
            data_o[b] = data_i[WORD_W-1:0];
          end
        end
        SH_X18: begin
          if (wi[1] == 1'((b >> 1) & 1)) begin
            we_o[b]   = fire_i;
            mask_o[b] = lm;
            data_o[b] = data_i[WORD_W*(b%2) +: WORD_W];
          end
        end
        SH_X36: begin
          we_o[b]   = fire_i;
          mask_o[b] = lm;
          data_o[b] = data_i[WORD_W*b +: WORD_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mwr_bank.sv
module mwr_bank #(
  parameter int WORD_W = 9,
  parameter int ROWS   = 128,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] wmask_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ROW_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= (mem[waddr_i] & ~wmask_i) | (wdata_i & wmask_i);
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/mwr_rd_sel.sv
module mwr_rd_sel
  import mwr_pkg::*;
(
  input  logic [2:0]                    width_i,
  input  logic [BANK_W-1:0]             bank_i,
  input  logic [2:0]                    off_i,
  input  logic [N_BANK-1:0][WORD_W-1:0] word_i,
  output logic [DATA_W-1:0]             data_o
);
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    sel_word = word_i[bank_i];
    data_o   = '0;
    case (width_i)
      SH_X1, SH_X2, SH_X4: data_o[WORD_W-1:0] = (sel_word >> off_i) & lane_mask(width_i);
      SH_X9:               data_o[WORD_W-1:0] = sel_word;
      SH_X18:              data_o[2*WORD_W-1:0] = {word_i[{bank_i[1], 1'b1}], word_i[{bank_i[1], 1'b0}]};
      SH_X36: begin
        for (int b = 0; b < N_BANK; b++) data_o[WORD_W*b +: WORD_W] = word_i[b];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mixed_width_ram.sv
module mixed_width_ram
  import mwr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic          rst_ni,
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [2:0]    w_width_i,
  input  logic [SW-1:0] w_sel_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic [2:0]    r_width_i,
  input  logic [SW-1:0] r_sel_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          pipe_i,
  input  logic [SW-1:0] blk_id_i
);
  logic                          wr_fire, rd_fire;
  logic [ROW_W-1:0]              wrow, rrow;
  logic [N_BANK-1:0]             bank_we;
  logic [N_BANK-1:0][WORD_W-1:0] bank_mask, bank_wdata, bank_rdata;
  logic [IDX_W-1:0]              rwi;
  logic [2:0]                    rw_q, roff_q;
  logic [BANK_W-1:0]             rbank_q;
  logic [DW-1:0]                 rsel_data, rpipe_q;

  assign wr_fire = we_i && (w_sel_i == blk_id_i);
  assign rd_fire = re_i && (r_sel_i == blk_id_i);

  mwr_wr_map u_wmap (
    .fire_i  (wr_fire),
    .width_i (w_width_i),
    .addr_i  (waddr_i),
    .data_i  (wdata_i),
    .row_o   (wrow),
    .we_o    (bank_we),
    .mask_o  (bank_mask),
    .data_o  (bank_wdata)
  );

  assign rwi  = word_idx(r_width_i, raddr_i);
  assign rrow = rwi[IDX_W-1:BANK_W];

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    mwr_bank #(.WORD_W(WORD_W), .ROWS(ROWS)) u_bank (
      .wclk_i  (wclk_i),
      .we_i    (bank_we[g]),
      .waddr_i (wrow),
      .wdata_i (bank_wdata[g]),
      .wmask_i (bank_mask[g]),
      .rclk_i  (rclk_i),
      .rst_ni  (rst_ni),
      .re_i    (rd_fire),
      .raddr_i (rrow),
      .rdata_o (bank_rdata[g])
    );
  end

  // shape and lane of the last accepted read, aligned with bank output regs
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q    <= '0;
      rbank_q <= '0;
      roff_q  <= '0;
    end else if (rd_fire) begin
      rw_q    <= r_width_i;
      rbank_q <= rwi[BANK_W-1:0];
      roff_q  <= bit_off(r_width_i, raddr_i);
    end
  end

  mwr_rd_sel u_rsel (
    .width_i (rw_q),
    .bank_i  (rbank_q),
    .off_i   (roff_q),
    .word_i  (bank_rdata),
    .data_o  (rsel_data)
  );

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rpipe_q <= '0;
    else         rpipe_q <= rsel_data;
  end

  assign rdata_o = pipe_i ? rpipe_q : rsel_data;
endmodule

// File: rtl/mixed_width_ram_chk.sv
module mixed_width_ram_chk
  import mwr_pkg::*;
(
  input logic              rst_ni,
  input logic              wclk_i,
  input logic              we_i,
  input logic [2:0]        w_width_i,
  input logic [SEL_W-1:0]  w_sel_i,
  input logic              rclk_i,
  input logic              re_i,
  input logic [2:0]        r_width_i,
  input logic [SEL_W-1:0]  r_sel_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              pipe_i,
  input logic [SEL_W-1:0]  blk_id_i,
  input logic [N_BANK-1:0] bank_we
);
  logic rd_go, wr_go;
  assign rd_go = re_i && (r_sel_i == blk_id_i);
  assign wr_go = we_i && (w_sel_i == blk_id_i);

  p_reserved_write_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_width_i > 3'd5) |-> (bank_we == '0));

  p_reserved_read_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!pipe_i && $past(rd_go) && ($past(r_width_i) > 3'd5)) |-> (rdata_o == '0));

  p_pipe_hold_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (pipe_i && !rd_go && !$past(rd_go)) |=> $stable(rdata_o));

  p_read_hold_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!pipe_i && !rd_go) |=> $stable(rdata_o));

  p_narrow_one_bank_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_go && (w_width_i <= 3'd3)) |-> ($countones(bank_we) == 1));

  p_wide_all_banks_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_go && (w_width_i == 3'd5)) |-> (&bank_we));

  p_stack_write_gate_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_sel_i != blk_id_i) |-> (bank_we == '0));

  p_zero_ext_narrow_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!pipe_i && $past(rd_go) && ($past(r_width_i) < 3'd3)) |-> (rdata_o[DATA_W-1:4] == '0));

  p_zero_ext_x9_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!pipe_i && $past(rd_go) && ($past(r_width_i) == 3'd3)) |-> (rdata_o[DATA_W-1:WORD_W] == '0));
endmodule

bind mixed_width_ram mixed_width_ram_chk u_chk (
  .rst_ni    (rst_ni),
  .wclk_i    (wclk_i),
  .we_i      (we_i),
  .w_width_i (w_width_i),
  .w_sel_i   (w_sel_i),
  .rclk_i    (rclk_i),
  .re_i      (re_i),
  .r_width_i (r_width_i),
  .r_sel_i   (r_sel_i),
  .rdata_o   (rdata_o),
  .pipe_i    (pipe_i),
  .blk_id_i  (blk_id_i),
  .bank_we   (bank_we)
);

// File: tb/mixed_width_ram_tb.sv
module mixed_width_ram_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int TOTAL_BITS  = 4608;
  localparam logic [3:0] MY_ID = 4'd5;

  logic        rst_n = 1'b0;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        we = 1'b0, re = 1'b0, pipe = 1'b0;
  logic [2:0]  w_width = '0, r_width = '0;
  logic [3:0]  w_sel = MY_ID, r_sel = MY_ID;
  logic [11:0] waddr = '0, raddr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;

  int total = 0;
  int bad = 0;
  logic ref_mem [TOTAL_BITS];

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  mixed_width_ram u_dut (
    .rst_ni(rst_n), .wclk_i(wclk), .we_i(we), .w_width_i(w_width), .w_sel_i(w_sel),
    .waddr_i(waddr), .wdata_i(wdata), .rclk_i(rclk), .re_i(re), .r_width_i(r_width),
    .r_sel_i(r_sel), .raddr_i(raddr), .rdata_o(rdata), .pipe_i(pipe), .blk_id_i(MY_ID)
  );

  function automatic int nbits(int w);
    case (w)
      0: return 1;  1: return 2;  2: return 4;
      3: return 9;  4: return 18; default: return 36;
    endcase
  endfunction

  function automatic int base_bit(int w, int a);
    int n = nbits(w);
    int depth = (w < 3) ? 4096 / n : TOTAL_BITS / n;
    int aa = a & (depth - 1);
    if (w < 3) return ((aa * n) / 8) * 9 + ((aa * n) % 8);
    return aa * n;
  endfunction

  function automatic logic [35:0] model_rd(int w, int a);
    logic [35:0] r = '0;
    if (w > 5) return r;
    for (int i = 0; i < nbits(w); i++) r[i] = ref_mem[base_bit(w, a) + i];
    return r;
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(int w, int a, logic [35:0] d, logic [3:0] sel);
    @(negedge wclk);
    we = 1'b1; w_width = 3'(w); waddr = 12'(a); wdata = d; w_sel = sel;
    @(posedge wclk);
    #1;
    if (w < 6 && sel == MY_ID)
      for (int i = 0; i < nbits(w); i++) ref_mem[base_bit(w, a) + i] = d[i];
    @(negedge wclk);
    we = 1'b0; w_sel = MY_ID;
  endtask

  task automatic do_read(int w, int a, logic [3:0] sel, output logic [35:0] early,
                         output logic [35:0] got);
    @(negedge rclk);
    re = 1'b1; r_width = 3'(w); raddr = 12'(a); r_sel = sel;
    @(posedge rclk);
    @(negedge rclk);
    early = rdata;
    re = 1'b0; r_sel = MY_ID; raddr = 12'($urandom);
    if (pipe) begin
      @(posedge rclk);
      @(negedge rclk);
    end
    got = rdata;
  endtask

  task automatic rd_check(string req, int w, int a);
    logic [35:0] e, g;
    do_read(w, a, MY_ID, e, g);
    check(req, g, model_rd(w, a));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] e, g, prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge rclk);
    check("R12 reset", rdata, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge rclk);
    check("R12 after release", rdata, '0);

    // fill everything through the widest shape
    for (int a = 0; a < 128; a++) do_write(5, a, {$urandom, $urandom}, MY_ID);

    // R7: 36-bit word split into 9-bit words
    do_write(5, 3, 36'h9_8765_4321, MY_ID);
    rd_check("R7 x9 lane0", 3, 12);
    rd_check("R7 x9 lane3", 3, 15);
    rd_check("R7 x18 upper", 4, 7);
    rd_check("R3 R7 x36", 5, 3);
    // R6: narrow packing, bit 8 untouched
    do_write(3, 40, 9'h1ff, MY_ID);
    do_write(0, 40 * 8 + 2, 36'h0, MY_ID);
    do_write(1, 40 * 4 + 3, 36'h1, MY_ID);
    rd_check("R6 R8 x9 after narrow", 3, 40);
    rd_check("R6 x4 read", 2, 81);
    rd_check("R10 x1 zero ext", 0, 40 * 8 + 7);
    // R1: upper address bits ignored
    do_write(5, 12'hf85, 36'h1_2345_6789, MY_ID);
    rd_check("R1 x36 alias", 5, 5);
    rd_check("R1 x9 alias", 3, 12'he15);
    // R2: reserved codes
    do_write(6, 9, 36'hf_ffff_ffff, MY_ID);
    do_write(7, 9, 36'hf_ffff_ffff, MY_ID);
    rd_check("R2 reserved write blocked", 5, 9);
    rd_check("R2 reserved read zero", 6, 9);
    // R9: stacking select
    do_write(5, 20, 36'h0_0000_0abc, 4'd4);
    rd_check("R9 foreign write ignored", 5, 20);
    rd_check("R9 prime", 5, 21);
    prev = rdata;
    do_read(5, 22, 4'd3, e, g);
    check("R9 foreign read holds", g, prev);
    // R5: hold with re low
    repeat (4) @(negedge rclk);
    check("R5 hold", rdata, prev);
    // R4: pipeline
    pipe = 1'b1;
    repeat (2) @(negedge rclk);
    prev = rdata;
    do_read(3, 100, MY_ID, e, g);
    check("R4 pipe early holds", e, prev);
    check("R4 pipe data", g, model_rd(3, 100));
    repeat (3) @(negedge rclk);
    check("R4 R5 pipe hold", rdata, g);
    pipe = 1'b0;
    repeat (2) @(negedge rclk);
    // R11: concurrent ports, disjoint halves
    fork
      for (int i = 0; i < 64; i++) do_write(3, 256 + i, 36'($urandom), MY_ID);
      for (int i = 0; i < 48; i++) rd_check("R11 concurrent", 3, i * 5);
    join
    // random mix, R8 cross-shape
    for (int blk = 0; blk < 6; blk++) begin
      pipe = 1'(blk % 2);
      repeat (2) @(negedge rclk);
      for (int i = 0; i < 150; i++) begin
        if ($urandom % 2 == 0) begin
          int w = ($urandom % 16 == 0) ? 6 + ($urandom % 2) : $urandom % 6;
          do_write(w, $urandom, {$urandom, $urandom}, MY_ID);
        end else begin
          rd_check("R8 random", $urandom % 8, $urandom);
        end
      end
    end
    pipe = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule